// File: doc/BRIEF.md
# PCI Target Address Decoder with Medium-Speed Device Select

This block sits at the front of the target side of a 32-bit PCI agent. It samples the address phase of every transaction on the bus and latches the address, the command nibble and the IDSEL pin. It works out whether the command names configuration, I/O or memory space. It checks the address against two programmable base address registers, or against IDSEL for configuration cycles. On a hit it drives DEVSEL# and TRDY# low with medium decode timing, and keeps them low until the master completes its final data phase.

The user side sees a one-clock request strobe along with the space type, the latched address and the read/write direction. It then sees a data-phase strobe for each I/O or memory transfer. On writes this strobe comes with the write data and the byte enables. The command register, a read-only status half and the two base address registers live inside the block. They answer configuration cycles directly. Read data is always a full 32-bit word, whatever the byte enables say. Bus signals are modelled as separate in, out and output-enable wires. Active-low bus pins carry the suffix `_n`.

Top module: `pci_tgt_front`

## Requirements
- R1: The command sampled on cbe_n at the address phase selects the space. 1010 and 1011 select configuration (req_space 00). 0010 and 0011 select I/O (req_space 01). 0110, 0111, 1100, 1110 and 1111 select memory (req_space 10). req_write equals bit 0 of the command, and req_addr holds the address-phase value of ad_in for the whole transaction.
- R2: A clock edge that samples frame_n low while the bus is idle is the address phase. After that edge devsel_n stays high for one cycle. A claimed transaction drives devsel_n and trdy_n low after the next edge, and req_valid is high for that cycle only. A transaction not claimed by then is never claimed.
- R3: A configuration command is claimed only when idsel is 1 and ad_in[1:0] is 00 at the address phase. The space-enable bits of the command register do not gate it.
- R4: Interrupt acknowledge (0000) is never claimed. Neither is any other code outside R1, such as 0001, 0100, 0101, 1000, 1001 or 1101.
- R5: A memory command is claimed only when command-register bit 1 is set and ad_in[31:MEM_AW] equals BAR0[31:MEM_AW]. An I/O command is claimed only when bit 0 is set and ad_in[31:IO_AW] equals BAR1[31:IO_AW].
- R6: In each data phase of a claimed I/O or memory write, dphase is 1, wr_be equals ~cbe_n (bit n high means byte n is written) and wr_data equals ad_in.
- R7: In each data phase of a claimed I/O or memory read, ad_oe is 1, ad_out equals the full 32-bit usr_rdata for any cbe_n value, and wr_be is 0000.
- R8: Configuration dword 1 (ad_in[7:2] = 1) reads {16'h0200, command}. Command bits 0, 1, 2, 6, 8 and 10 are writable, under byte enables 0 and 1. Bit 7, the stepping control, always reads 0. The upper half ignores writes.
- R9: Configuration dword 4 is BAR0, which is writable in bits [31:MEM_AW] with the lower bits reading 0. Dword 5 is BAR1, which is writable in bits [31:IO_AW], with bit 0 reading 1 and the other low bits reading 0. Each byte is written only if its byte enable is low.
- R10: After an edge where frame_n is high and irdy_n and trdy_n are both low, devsel_n and trdy_n are high in the next cycle.
- R11: After reset devsel_n and trdy_n are high, and req_valid, ad_oe and dphase are 0. The command register and both BAR address fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Bus FRAME#, low while the master owns a transaction |
| irdy_n | input | 1 | Bus IRDY#, master ready |
| idsel | input | 1 | Configuration select for this agent |
| cbe_n | input | 4 | Command at the address phase, active-low byte enables afterwards |
| ad_in | input | 32 | Address/data bus as seen by the target |
| usr_rdata | input | 32 | Read data supplied by the user side |
| devsel_n | output | 1 | Bus DEVSEL#, active low |
| trdy_n | output | 1 | Bus TRDY#, active low |
| ad_out | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | Drive enable for ad_out |
| req_valid | output | 1 | One-cycle strobe for a newly claimed transaction |
| req_space | output | 2 | 00 configuration, 01 I/O, 10 memory |
| req_addr | output | 32 | Latched address-phase address |
| req_write | output | 1 | 1 for a write command |
| dphase | output | 1 | An I/O or memory data transfer happens at the next edge |
| wr_be | output | 4 | Active-high write byte enables, 0 on reads |
| wr_data | output | 32 | Write data passed from the bus |

## Verification
The decoder is driven with every command code. Claimed codes are checked for space and direction, and unclaimed codes, interrupt acknowledge among them, must leave devsel_n high through the cycle after the medium slot. Configuration cycles with idsel low or a misaligned address, memory and I/O cycles just outside their windows, and cycles with an enable bit clear show which term of each hit equation gates the claim. A write burst with a different byte-enable pattern in every phase and a read burst with arbitrary byte enables separate write pass-through from byte enables that reads ignore. Partial-byte configuration writes and a write to the stepping bit show which register bits are writable.

// File: rtl/pci_tgt_front.sv
module pci_tgt_front #(
  parameter int          MEM_AW    = 12,
  parameter int          IO_AW     = 8,
  parameter logic [15:0] CMD_WMASK = 16'h0547,
  parameter logic [15:0] STATUS_RO = 16'h0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  input  logic [31:0] usr_rdata,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        req_valid,
  output logic [1:0]  req_space,
  output logic [31:0] req_addr,
  output logic        req_write,
  output logic        dphase,
  output logic [3:0]  wr_be,
  output logic [31:0] wr_data
);

  localparam logic [1:0]  SP_CFG    = 2'b00;
  localparam logic [1:0]  SP_IO     = 2'b01;
  localparam logic [1:0]  SP_MEM    = 2'b10;
  localparam logic [5:0]  REG_CMD   = 6'd1;
  localparam logic [5:0]  REG_BAR0  = 6'd4;
  localparam logic [5:0]  REG_BAR1  = 6'd5;
  localparam logic [31:0] BAR0_MASK = ~((32'd1 << MEM_AW) - 32'd1);
  localparam logic [31:0] BAR1_MASK = ~((32'd1 << IO_AW) - 32'd1);
  localparam logic [15:0] CMD_MASK  = CMD_WMASK & 16'hFF7F;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_ACT, S_WAIT} st_t;

  st_t         st_q;
  logic [3:0]  lat_cmd;
  logic [31:0] lat_addr;
  logic        lat_idsel;
  logic [1:0]  space_q;
  logic        devsel_q, trdy_q, req_q;
  logic [15:0] cmd_reg;
  logic [31:0] bar0_q, bar1_q;

  function automatic logic [31:0] bmerge(input logic [31:0] old_v, input logic [31:0] new_v,
                                         input logic [3:0] ben);
    logic [31:0] res;
    for (int b = 0; b < 4; b++)
      res[8*b +: 8] = ben[b] ? old_v[8*b +: 8] : new_v[8*b +: 8];
    return res;
  endfunction

  logic is_cfg, is_io, is_mem, cfg_hit, io_hit, mem_hit, hit;
  logic [1:0] hit_space;

  assign is_cfg  = (lat_cmd[3:1] == 3'b101);
  assign is_io   = (lat_cmd[3:1] == 3'b001);
  assign is_mem  = lat_cmd inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
  assign cfg_hit = is_cfg && lat_idsel && (lat_addr[1:0] == 2'b00);
  assign io_hit  = is_io && cmd_reg[0] && (lat_addr[31:IO_AW] == bar1_q[31:IO_AW]);
  assign mem_hit = is_mem && cmd_reg[1] && (lat_addr[31:MEM_AW] == bar0_q[31:MEM_AW]);
  assign hit     = cfg_hit || io_hit || mem_hit;
  assign hit_space = cfg_hit ? SP_CFG : (io_hit ? SP_IO : SP_MEM);

  logic xfer;
  assign xfer = (st_q == S_ACT) && !irdy_n && !trdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      lat_cmd   <= 4'h0;
      lat_addr  <= '0;
      lat_idsel <= 1'b0;
      space_q   <= SP_CFG;
      devsel_q  <= 1'b1;
      trdy_q    <= 1'b1;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st_q)
        S_IDLE: if (!frame_n) begin
          lat_cmd   <= cbe_n;
          lat_addr  <= ad_in;
          lat_idsel <= idsel;
          st_q      <= S_DEC;
        end
        S_DEC: if (hit) begin
          st_q     <= S_ACT;
          devsel_q <= 1'b0;
          trdy_q   <= 1'b0;
          req_q    <= 1'b1;
          space_q  <= hit_space;
        end else begin
          st_q <= S_WAIT;
        end
        S_ACT: if (xfer && frame_n) begin
          st_q     <= S_IDLE;
          devsel_q <= 1'b1;
          trdy_q   <= 1'b1;
        end
        default: if (frame_n && irdy_n) st_q <= S_IDLE;
      endcase
    end
  end

  logic        cfg_wr;
  logic [15:0] cmd_nx;
  logic [31:0] bar0_m, bar1_m;

  assign cfg_wr = xfer && (space_q == SP_CFG) && lat_cmd[0];
  assign cmd_nx = {cbe_n[1] ? cmd_reg[15:8] : ad_in[15:8],
                   cbe_n[0] ? cmd_reg[7:0]  : ad_in[7:0]};
  assign bar0_m = bmerge(bar0_q, ad_in, cbe_n);
  assign bar1_m = bmerge(bar1_q, ad_in, cbe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_reg <= '0;
      bar0_q  <= '0;
      bar1_q  <= '0;
    end else if (cfg_wr) begin
      case (lat_addr[7:2])
        REG_CMD:  cmd_reg <= cmd_nx & CMD_MASK;
        REG_BAR0: bar0_q  <= bar0_m & BAR0_MASK;
        REG_BAR1: bar1_q  <= bar1_m & BAR1_MASK;
        default: ;
      endcase
    end
  end

  logic [31:0] cfg_rdata;
  always_comb begin
    case (lat_addr[7:2])
      REG_CMD:  cfg_rdata = {STATUS_RO, cmd_reg};
      REG_BAR0: cfg_rdata = bar0_q;
      REG_BAR1: cfg_rdata = bar1_q | 32'd1;
      default:  cfg_rdata = '0;
    endcase
  end

  assign devsel_n  = devsel_q;
  assign trdy_n    = trdy_q;
  assign req_valid = req_q;
  assign req_space = space_q;
  assign req_addr  = lat_addr;
  assign req_write = lat_cmd[0];
  assign ad_oe     = (st_q == S_ACT) && !lat_cmd[0];
  assign ad_out    = (space_q == SP_CFG) ? cfg_rdata : usr_rdata;
  assign dphase    = xfer && (space_q != SP_CFG);
  assign wr_be     = (dphase && lat_cmd[0]) ? ~cbe_n : 4'b0000;
  assign wr_data   = ad_in;

  // R2
  devsel_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n, 2));

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($fell(devsel_n) && $fell(trdy_n)));

  // R4
  intack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DEC && lat_cmd == 4'b0000) |=> devsel_n);

  // R5
  mem_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DEC && is_mem && !cmd_reg[1]) |=> devsel_n);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !irdy_n && !trdy_n && frame_n) |=> (devsel_n && trdy_n));

  // R7
  rd_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (wr_be == 4'b0000));

  // R8
  stepping_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ACT && space_q == SP_CFG && !lat_cmd[0] && lat_addr[7:2] == REG_CMD) |-> !ad_out[7]);

endmodule

// File: tb/pci_tgt_front_tb.sv
`timescale 1ns/1ps
module pci_tgt_front_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0, usr_rdata = '0;
  logic        devsel_n, trdy_n, ad_oe, req_valid, req_write, dphase;
  logic [31:0] ad_out, req_addr, wr_data;
  logic [1:0]  req_space;
  logic [3:0]  wr_be;

  always #2.5 clk = ~clk;

  pci_tgt_front dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .usr_rdata(usr_rdata), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .ad_out(ad_out), .ad_oe(ad_oe), .req_valid(req_valid),
    .req_space(req_space), .req_addr(req_addr), .req_write(req_write),
    .dphase(dphase), .wr_be(wr_be), .wr_data(wr_data)
  );

  int vectors = 0, fails = 0;

  logic [31:0] ph_wd [8];
  logic [3:0]  ph_be [8];
  logic [31:0] ph_ur [8];
  logic [31:0] ph_rd [8];
  logic [31:0] ph_wdat [8];
  logic [3:0]  ph_wbe [8];
  logic        ph_dp [8];
  logic        ph_oe [8];
  logic        cap_valid, cap_valid_next, cap_write, cap_trdy;
  logic [1:0]  cap_space, cap_rel;
  logic [31:0] cap_addr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic id,
                     input int n, input string tag, output logic claimed);
    frame_n = 1'b0; irdy_n = 1'b1; cbe_n = cmd; ad_in = addr; idsel = id;
    @(posedge clk); #1;
    chk({tag, " R2 devsel high in first clock"}, {31'd0, devsel_n}, 32'd1);
    frame_n = (n == 1); irdy_n = 1'b0; idsel = 1'b0;
    cbe_n = ~ph_be[0]; ad_in = ph_wd[0]; usr_rdata = ph_ur[0];
    @(posedge clk); #1;
    claimed   = !devsel_n;
    cap_valid = req_valid; cap_space = req_space; cap_addr = req_addr;
    cap_write = req_write; cap_trdy = trdy_n;
    if (!claimed) begin
      @(posedge clk); #1;
      chk({tag, " R2 no late claim"}, {31'd0, devsel_n}, 32'd1);
      frame_n = 1'b1; irdy_n = 1'b1;
      @(posedge clk); #1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        frame_n = (i == n - 1); cbe_n = ~ph_be[i]; ad_in = ph_wd[i]; usr_rdata = ph_ur[i];
        #1;
      end
      ph_rd[i] = ad_out; ph_wdat[i] = wr_data; ph_wbe[i] = wr_be;
      ph_dp[i] = dphase; ph_oe[i] = ad_oe;
      @(posedge clk); #1;
      if (i == 0) cap_valid_next = req_valid;
    end
    cap_rel = {devsel_n, trdy_n};
    frame_n = 1'b1; irdy_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic cfg_wr(input logic [5:0] rg, input logic [31:0] d, input logic [3:0] be);
    logic c;
    ph_wd[0] = d; ph_be[0] = be;
    txn(4'b1011, {24'd0, rg, 2'b00}, 1'b1, 1, "cfg write", c);
    chk("R3 cfg write claimed", {31'd0, c}, 32'd1);
  endtask

  task automatic cfg_rd(input logic [5:0] rg, input logic [31:0] exp, input string tag);
    logic c;
    ph_wd[0] = '0; ph_be[0] = 4'hF;
    txn(4'b1010, {24'd0, rg, 2'b00}, 1'b1, 1, tag, c);
    chk({tag, " claimed"}, {31'd0, c}, 32'd1);
    chk({tag, " R1 cfg space"}, {30'd0, cap_space}, 32'd0);
    chk(tag, ph_rd[0], exp);
  endtask

  task automatic expect_unclaimed(input logic [3:0] cmd, input logic [31:0] addr, input logic id,
                                  input string tag);
    logic c;
    ph_wd[0] = '0; ph_be[0] = 4'hF;
    txn(cmd, addr, id, 1, tag, c);
    chk(tag, {31'd0, c}, 32'd0);
  endtask

  task automatic test_reset();
    chk("R11 devsel_n after reset", {31'd0, devsel_n}, 32'd1);
    chk("R11 trdy_n after reset", {31'd0, trdy_n}, 32'd1);
    chk("R11 strobes after reset", {29'd0, req_valid, ad_oe, dphase}, 32'd0);
    cfg_rd(6'd1, 32'h0200_0000, "R11 command reset value");
    cfg_rd(6'd4, 32'h0000_0000, "R11 BAR0 reset value");
    cfg_rd(6'd5, 32'h0000_0001, "R11 BAR1 reset value");
  endtask

  task automatic test_cfg_regs();
    cfg_wr(6'd1, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(6'd1, 32'h0200_0547, "R8 command writable mask, bit 7 zero");
    cfg_wr(6'd1, 32'h0000_0080, 4'hF);
    cfg_rd(6'd1, 32'h0200_0000, "R8 stepping bit ignores write");
    expect_unclaimed(4'b1010, 32'h0000_0004, 1'b0, "R3 cfg with idsel low");
    expect_unclaimed(4'b1010, 32'h0000_0005, 1'b1, "R3 cfg with ad[1:0]=01");
    cfg_wr(6'd4, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(6'd4, 32'hFFFF_F000, "R9 BAR0 size bits");
    cfg_wr(6'd4, 32'h1234_5678, 4'b1000);
    cfg_rd(6'd4, 32'h12FF_F000, "R9 BAR0 single byte write");
    cfg_wr(6'd4, 32'h8000_0000, 4'hF);
    cfg_rd(6'd4, 32'h8000_0000, "R9 BAR0 programmed");
    cfg_wr(6'd5, 32'hFFFF_FFFF, 4'hF);
    cfg_rd(6'd5, 32'hFFFF_FF01, "R9 BAR1 size bits");
    cfg_wr(6'd5, 32'h0000_C000, 4'hF);
    cfg_rd(6'd5, 32'h0000_C001, "R9 BAR1 programmed");
  endtask

  task automatic test_enable();
    logic c;
    expect_unclaimed(4'b0110, 32'h8000_0010, 1'b0, "R5 memory disabled");
    expect_unclaimed(4'b0010, 32'h0000_C004, 1'b0, "R5 io disabled");
    cfg_wr(6'd1, 32'h0000_0002, 4'hF);
    expect_unclaimed(4'b0010, 32'h0000_C004, 1'b0, "R5 io still disabled");
    ph_wd[0] = '0; ph_be[0] = 4'hF;
    txn(4'b0110, 32'h8000_0010, 1'b0, 1, "R5 mem enabled", c);
    chk("R5 memory claimed when enabled", {31'd0, c}, 32'd1);
    cfg_wr(6'd1, 32'h0000_0003, 4'hF);
    expect_unclaimed(4'b0110, 32'h8000_1000, 1'b0, "R5 memory just above window");
    expect_unclaimed(4'b0110, 32'h7FFF_FFFC, 1'b0, "R5 memory just below window");
    expect_unclaimed(4'b0011, 32'h0000_C100, 1'b0, "R5 io just above window");
  endtask

  task automatic test_timing();
    logic c;
    ph_wd[0] = '0; ph_be[0] = 4'hF; ph_ur[0] = 32'h5555_AAAA;
    txn(4'b0110, 32'h8000_0ABC, 1'b0, 1, "R2 timing", c);
    chk("R2 claimed in second clock", {31'd0, c}, 32'd1);
    chk("R2 trdy_n low with devsel_n", {31'd0, cap_trdy}, 32'd0);
    chk("R2 req_valid in claim cycle", {31'd0, cap_valid}, 32'd1);
    chk("R2 req_valid one cycle", {31'd0, cap_valid_next}, 32'd0);
    chk("R1 memory space", {30'd0, cap_space}, 32'd2);
    chk("R1 latched address", cap_addr, 32'h8000_0ABC);
    chk("R1 read direction", {31'd0, cap_write}, 32'd0);
    chk("R10 release after single phase", {30'd0, cap_rel}, 32'd3);
  endtask

  task automatic test_wr_burst();
    logic c;
    logic [3:0] bes [4] = '{4'b1111, 4'b0001, 4'b1010, 4'b0000};
    for (int i = 0; i < 4; i++) begin ph_wd[i] = 32'h1111_0000 + i; ph_be[i] = bes[i]; ph_ur[i] = '0; end
    txn(4'b0111, 32'h8000_0100, 1'b0, 4, "R6 burst", c);
    chk("R6 burst claimed", {31'd0, c}, 32'd1);
    chk("R1 write direction", {31'd0, cap_write}, 32'd1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 write byte enables", {28'd0, ph_wbe[i]}, {28'd0, bes[i]});
      chk("R6 write data", ph_wdat[i], 32'h1111_0000 + i);
      chk("R6 data phase strobe", {30'd0, ph_dp[i], ph_oe[i]}, 32'd2);
    end
    chk("R10 release after burst", {30'd0, cap_rel}, 32'd3);
  endtask

  task automatic test_rd_burst();
    logic c;
    logic [3:0]  bes [3] = '{4'b0000, 4'b0101, 4'b1111};
    logic [31:0] urs [3] = '{32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF};
    for (int i = 0; i < 3; i++) begin ph_wd[i] = '0; ph_be[i] = bes[i]; ph_ur[i] = urs[i]; end
    txn(4'b1100, 32'h8000_0200, 1'b0, 3, "R7 read burst", c);
    chk("R7 read burst claimed", {31'd0, c}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      chk("R7 full word returned", ph_rd[i], urs[i]);
      chk("R7 no write byte enables", {28'd0, ph_wbe[i]}, 32'd0);
      chk("R7 drive enable and strobe", {30'd0, ph_dp[i], ph_oe[i]}, 32'd3);
    end
    chk("R10 release after read burst", {30'd0, cap_rel}, 32'd3);
  endtask

  task automatic test_io();
    logic c;
    ph_wd[0] = 32'hCAFE_0001; ph_be[0] = 4'b0011;
    txn(4'b0011, 32'h0000_C004, 1'b0, 1, "R1 io write", c);
    chk("R1 io write claimed", {31'd0, c}, 32'd1);
    chk("R1 io space", {30'd0, cap_space}, 32'd1);
    chk("R1 io write direction", {31'd0, cap_write}, 32'd1);
    chk("R6 io write byte enables", {28'd0, ph_wbe[0]}, 32'h3);
    ph_be[0] = 4'hF; ph_ur[0] = 32'h0BAD_F00D;
    txn(4'b0010, 32'h0000_C0FC, 1'b0, 1, "R1 io read", c);
    chk("R1 io read claimed", {31'd0, c}, 32'd1);
    chk("R7 io read data", ph_rd[0], 32'h0BAD_F00D);
  endtask

  task automatic test_unclaimed();
    logic [3:0] codes [7] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1101};
    for (int i = 0; i < 7; i++)
      expect_unclaimed(codes[i], 32'h8000_0000, 1'b1, "R4 command not claimed");
  endtask

  task automatic test_memcmds();
    logic c;
    logic [3:0] codes [5] = '{4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111};
    for (int i = 0; i < 5; i++) begin
      ph_wd[0] = '0; ph_be[0] = 4'hF;
      txn(codes[i], 32'h8000_0040, 1'b0, 1, "R1 memory command", c);
      chk("R1 memory command claimed", {31'd0, c}, 32'd1);
      chk("R1 memory command space", {30'd0, cap_space}, 32'd2);
      chk("R1 memory command direction", {31'd0, cap_write}, {31'd0, codes[i][0]});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    test_reset();
    test_cfg_regs();
    test_enable();
    test_timing();
    test_wr_burst();
    test_rd_burst();
    test_io();
    test_unclaimed();
    test_memcmds();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule